// File: doc/BRIEF.md
# Banked Register File with Segment Registers

This block is the register storage of a small 8-bit processor core. It holds sixteen 8-bit physical registers: six general registers named r0 to r5, a stack pointer, an instruction pointer, a second set of r0 to r3, and four segment registers (code, data, extra, stack). Instructions name a register with a 3-bit number. The block turns that number into a 4-bit physical index. For r0 to r3, the top index bit comes from a bank flag. Registers r4, r5, the stack pointer and the instruction pointer are never banked.

Each of the two read ports and the single write port has its own addressing mode. In the current-bank mode the stored bank flag picks the bank. In the explicit-bank mode a per-port bank bit picks it instead, as an instruction field does when it names the bank directly. The segment mode reaches the segment registers through a 2-bit selector, and the raw mode takes a full physical index. The bank flag has its own set and clear controls. Decoding, arithmetic and memory sit outside the block. All ports are plain control and data pins: there is no streaming handshake, so a read is valid in the same cycle as its address, and a write is always accepted.

Top module: `banked_regfile`

## Requirements
- R1: While rst_n is low, all sixteen registers and the bank flag are cleared to 0. After reset, every register reads 0 and bank_sel is 0.
- R2: Mode 2'b00 (current bank) maps a register number n to the physical index {bank_sel, n} when n[2] is 0, and to {0, n} when n[2] is 1. Numbers 4 and 5 (r4, r5), 6 (stack pointer) and 7 (instruction pointer) therefore ignore the bank flag.
- R3: Mode 2'b01 (explicit bank) maps n to {xbank, n} when n[2] is 0, and to {0, n} when n[2] is 1. The stored bank flag is not used in this mode.
- R4: Mode 2'b10 (segment) maps n[1:0] to physical index 12 + n[1:0]: 0 is the code segment, 1 the data segment, 2 the extra segment, 3 the stack segment. Bit n[2] has no effect in this mode.
- R5: Mode 2'b11 (raw) maps n to physical index {xbank, n}. Physical indices 0 to 5 are r0 to r5, 6 is the stack pointer, 7 is the instruction pointer, 8 to 11 are bank-1 r0 to r3, and 12 to 15 are the segment registers.
- R6: When we is 1 at a rising clock edge, wd is stored in the register that wa_mode, wa_num and wa_xbank select. When we is 0, no register changes, whatever wd holds.
- R7: The read ports are combinational and have no write bypass. In the cycle of a write, a read of the target register returns the old value. From the cycle after the edge, it returns the new value.
- R8: bank_set drives bank_sel to 1 at the next edge, and bank_clr drives it to 0. When both are high, clear wins. When neither is high, bank_sel holds its value.
- R9: The two read ports are independent. Each returns its own register in the same cycle, whatever the other port is addressing.
- R10: A write in the same cycle as a bank change uses the bank flag as it was before that edge. Reads see the new flag from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_set | input | 1 | Set the bank flag to 1 at the next edge |
| bank_clr | input | 1 | Clear the bank flag to 0 at the next edge (has priority) |
| bank_sel | output | 1 | Current bank flag |
| ra_mode | input | 2 | Read port A addressing mode |
| ra_num | input | 3 | Read port A register number |
| ra_xbank | input | 1 | Read port A bank bit for the explicit and raw modes |
| ra_data | output | 8 | Read port A data |
| rb_mode | input | 2 | Read port B addressing mode |
| rb_num | input | 3 | Read port B register number |
| rb_xbank | input | 1 | Read port B bank bit for the explicit and raw modes |
| rb_data | output | 8 | Read port B data |
| we | input | 1 | Write enable |
| wa_mode | input | 2 | Write port addressing mode |
| wa_num | input | 3 | Write port register number |
| wa_xbank | input | 1 | Write port bank bit for the explicit and raw modes |
| wd | input | 8 | Write data |

## Verification
The mapping is exercised by writing through one mode and reading back through another. A current-bank write is read back in raw mode under both flag values, which shows whether the flag reaches bit 3 only for numbers below 4. Explicit-bank writes are made while the flag is set to the opposite value, which separates the per-port bank bit from the stored flag. Segment writes with n[2] set show that the segment selector ignores that bit and never lands on r4 to r7. Same-cycle patterns cover the remaining behaviour: a read during its own write, a bank change together with a write, set and clear asserted together, and two ports reading different registers. These tell apart a bypassed read from a registered one, and an old flag from a new one.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int REG_W     = 8;
  localparam int LNUM_W    = 3;
  localparam int PIDX_W    = LNUM_W + 1;
  localparam int NREGS     = 1 << PIDX_W;
  localparam int SEG_SEL_W = 2;
  localparam int MODE_W    = 2;

  typedef enum logic [MODE_W-1:0] {
    AM_CUR  = 2'b00,
    AM_EXPL = 2'b01,
    AM_SEG  = 2'b10,
    AM_RAW  = 2'b11
  } addr_mode_e;

  typedef logic [PIDX_W-1:0] pidx_t;
endpackage

// File: rtl/reg_index_map.sv
module reg_index_map
  import regbank_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [LNUM_W-1:0] num,
  input  logic              xbank,
  input  logic              cur_bank,
  output pidx_t             idx
);
  localparam int SEG_TOP_W = PIDX_W - SEG_SEL_W;

  logic unbanked;
  assign unbanked = num[LNUM_W-1];

  always_comb begin
    case (addr_mode_e'(mode))
      AM_CUR:  idx = unbanked ? {1'b0, num} : {cur_bank, num};
      AM_EXPL: idx = unbanked ? {1'b0, num} : {xbank, num};
      AM_SEG:  idx = {{SEG_TOP_W{1'b1}}, num[SEG_SEL_W-1:0]};
      default: idx = {xbank, num};
    endcase
  end
endmodule

// File: rtl/bank_flag.sv
module bank_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (clr_i) flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
  end
endmodule

// File: rtl/reg_array.sv
module reg_array #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wd,
  input  logic [IDX_W-1:0]  ridx_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [IDX_W-1:0]  ridx_b,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] cells [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cells[i] <= '0;
      else if (we && (widx == IDX_W'(i)))
        cells[i] <= wd;
    end
  end

  assign rdata_a = cells[ridx_a];
  assign rdata_b = cells[ridx_b];
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import regbank_pkg::*;
#(
  parameter int DATA_W = REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_set,
  input  logic              bank_clr,
  output logic              bank_sel,
  input  logic [1:0]        ra_mode,
  input  logic [2:0]        ra_num,
  input  logic              ra_xbank,
  output logic [DATA_W-1:0] ra_data,
  input  logic [1:0]        rb_mode,
  input  logic [2:0]        rb_num,
  input  logic              rb_xbank,
  output logic [DATA_W-1:0] rb_data,
  input  logic              we,
  input  logic [1:0]        wa_mode,
  input  logic [2:0]        wa_num,
  input  logic              wa_xbank,
  input  logic [DATA_W-1:0] wd
);
  pidx_t idx_a, idx_b, idx_w;

  bank_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_i(bank_set), .clr_i(bank_clr), .flag_o(bank_sel)
  );

  reg_index_map u_map_a (
    .mode(ra_mode), .num(ra_num), .xbank(ra_xbank), .cur_bank(bank_sel), .idx(idx_a)
  );
  reg_index_map u_map_b (
    .mode(rb_mode), .num(rb_num), .xbank(rb_xbank), .cur_bank(bank_sel), .idx(idx_b)
  );
  reg_index_map u_map_w (
    .mode(wa_mode), .num(wa_num), .xbank(wa_xbank), .cur_bank(bank_sel), .idx(idx_w)
  );

  reg_array #(.DATA_W(DATA_W), .IDX_W(PIDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(we), .widx(idx_w), .wd(wd),
    .ridx_a(idx_a), .rdata_a(ra_data), .ridx_b(idx_b), .rdata_b(rb_data)
  );
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bank_set,
  input logic              bank_clr,
  input logic              bank_sel,
  input logic              we,
  input logic [1:0]        ra_mode,
  input logic [2:0]        ra_num,
  input logic              ra_xbank,
  input logic [DATA_W-1:0] ra_data,
  input logic [1:0]        rb_mode,
  input logic [2:0]        rb_num,
  input logic              rb_xbank,
  input logic [DATA_W-1:0] rb_data
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_BANK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_set && !bank_clr) |=> bank_sel); // R8
  AST_BANK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    bank_clr |=> !bank_sel); // R8
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bank_set && !bank_clr) |=> $stable(bank_sel)); // R8
  AST_CUR_MATCHES_EXPL: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_mode == 2'b00 && rb_mode == 2'b01 && ra_num == rb_num && rb_xbank == bank_sel)
      |-> ra_data == rb_data); // R2
  AST_HIGH_NUM_UNBANKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_mode == 2'b00 && rb_mode == 2'b01 && ra_num == rb_num && ra_num[2])
      |-> ra_data == rb_data); // R3
  AST_SEG_IS_RAW_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_mode == 2'b11 && ra_xbank && ra_num[2] && rb_mode == 2'b10 &&
     rb_num[1:0] == ra_num[1:0]) |-> ra_data == rb_data); // R4
  AST_IDLE_READ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(!we) && $past(!bank_set) && $past(!bank_clr) &&
     $stable(ra_mode) && $stable(ra_num) && $stable(ra_xbank)) |-> $stable(ra_data)); // R6
endmodule

bind banked_regfile banked_regfile_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bank_set(bank_set), .bank_clr(bank_clr),
  .bank_sel(bank_sel), .we(we),
  .ra_mode(ra_mode), .ra_num(ra_num), .ra_xbank(ra_xbank), .ra_data(ra_data),
  .rb_mode(rb_mode), .rb_num(rb_num), .rb_xbank(rb_xbank), .rb_data(rb_data)
);

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;
  localparam logic [1:0] M_CUR = 2'b00, M_EXPL = 2'b01, M_SEG = 2'b10, M_RAW = 2'b11;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bank_set = 1'b0, bank_clr = 1'b0, bank_sel;
  logic [1:0] ra_mode = '0, rb_mode = '0, wa_mode = '0;
  logic [2:0] ra_num = '0, rb_num = '0, wa_num = '0;
  logic       ra_xbank = 1'b0, rb_xbank = 1'b0, wa_xbank = 1'b0;
  logic [7:0] ra_data, rb_data, wd = '0;
  logic       we = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  banked_regfile u_banked_regfile (
    .clk(clk), .rst_n(rst_n), .bank_set(bank_set), .bank_clr(bank_clr), .bank_sel(bank_sel),
    .ra_mode(ra_mode), .ra_num(ra_num), .ra_xbank(ra_xbank), .ra_data(ra_data),
    .rb_mode(rb_mode), .rb_num(rb_num), .rb_xbank(rb_xbank), .rb_data(rb_data),
    .we(we), .wa_mode(wa_mode), .wa_num(wa_num), .wa_xbank(wa_xbank), .wd(wd)
  );

  task automatic chk(input string req, input string what, input logic [7:0] got,
                     input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] m, input logic [2:0] n, input logic xb,
                    input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; wa_mode = m; wa_num = n; wa_xbank = xb; wd = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_a(input logic [1:0] m, input logic [2:0] n, input logic xb,
                      output logic [7:0] d);
    @(negedge clk);
    ra_mode = m; ra_num = n; ra_xbank = xb;
    #1 d = ra_data;
  endtask

  task automatic raw(input int idx, output logic [7:0] d);
    rd_a(M_RAW, 3'(idx), idx[3], d);
  endtask

  task automatic pulse_bank(input logic s, input logic c);
    @(negedge clk);
    bank_set = s; bank_clr = c;
    @(negedge clk);
    bank_set = 1'b0; bank_clr = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R1", "bank_sel after reset", {7'b0, bank_sel}, 8'h00);
    for (int i = 0; i < 16; i++) begin
      raw(i, d);
      chk("R1", $sformatf("reg %0d after reset", i), d, 8'h00);
    end
  endtask

  task automatic t_current_bank();
    logic [7:0] d;
    wr(M_CUR, 3'd0, 1'b0, 8'h11);
    pulse_bank(1'b1, 1'b0);
    chk("R8", "bank_sel after set", {7'b0, bank_sel}, 8'h01);
    wr(M_CUR, 3'd0, 1'b0, 8'h22);
    raw(0, d);  chk("R2", "phys 0", d, 8'h11);
    raw(8, d);  chk("R2", "phys 8", d, 8'h22);
    rd_a(M_CUR, 3'd0, 1'b0, d); chk("R2", "r0 bank1", d, 8'h22);
    wr(M_CUR, 3'd6, 1'b0, 8'h66);
    wr(M_CUR, 3'd5, 1'b0, 8'h55);
    raw(6, d);  chk("R2", "sp unbanked", d, 8'h66);
    raw(14, d); chk("R2", "no write to phys 14", d, 8'h00);
    raw(5, d);  chk("R2", "r5 unbanked", d, 8'h55);
    raw(13, d); chk("R2", "no write to phys 13", d, 8'h00);
    pulse_bank(1'b0, 1'b1);
    chk("R8", "bank_sel after clear", {7'b0, bank_sel}, 8'h00);
    rd_a(M_CUR, 3'd0, 1'b0, d); chk("R2", "r0 bank0", d, 8'h11);
  endtask

  task automatic t_explicit_bank();
    logic [7:0] d;
    wr(M_EXPL, 3'd3, 1'b1, 8'h3b);
    raw(11, d); chk("R3", "phys 11 via explicit bank", d, 8'h3b);
    raw(3, d);  chk("R3", "phys 3 untouched", d, 8'h00);
    wr(M_EXPL, 3'd7, 1'b1, 8'h77);
    raw(7, d);  chk("R3", "ip unbanked", d, 8'h77);
    raw(15, d); chk("R3", "phys 15 untouched", d, 8'h00);
    pulse_bank(1'b1, 1'b0);
    rd_a(M_EXPL, 3'd3, 1'b0, d); chk("R3", "explicit bank0 ignores flag", d, 8'h00);
    pulse_bank(1'b0, 1'b1);
  endtask

  task automatic t_segments();
    logic [7:0] d;
    wr(M_SEG, 3'b101, 1'b0, 8'hd5);
    raw(13, d); chk("R4", "data segment", d, 8'hd5);
    raw(5, d);  chk("R4", "r5 untouched", d, 8'h55);
    wr(M_SEG, 3'b000, 1'b0, 8'hc0);
    wr(M_SEG, 3'b110, 1'b1, 8'he0);
    wr(M_SEG, 3'b011, 1'b0, 8'hf0);
    raw(12, d); chk("R4", "code segment", d, 8'hc0);
    raw(14, d); chk("R4", "extra segment", d, 8'he0);
    raw(15, d); chk("R4", "stack segment", d, 8'hf0);
    raw(7, d);  chk("R4", "ip untouched", d, 8'h77);
  endtask

  task automatic t_raw();
    logic [7:0] d;
    wr(M_RAW, 3'd0, 1'b1, 8'h80);
    pulse_bank(1'b1, 1'b0);
    rd_a(M_CUR, 3'd0, 1'b0, d); chk("R5", "raw write seen at bank1 r0", d, 8'h80);
    pulse_bank(1'b0, 1'b1);
    rd_a(M_CUR, 3'd0, 1'b0, d); chk("R5", "bank0 r0 untouched", d, 8'h11);
  endtask

  task automatic t_no_write();
    logic [7:0] d;
    @(negedge clk);
    we = 1'b0; wa_mode = M_RAW; wa_num = 3'd0; wa_xbank = 1'b0; wd = 8'hff;
    @(negedge clk);
    raw(0, d); chk("R6", "we low leaves reg", d, 8'h11);
  endtask

  task automatic t_no_bypass();
    logic [7:0] d;
    @(negedge clk);
    we = 1'b1; wa_mode = M_RAW; wa_num = 3'd2; wa_xbank = 1'b0; wd = 8'ha2;
    ra_mode = M_RAW; ra_num = 3'd2; ra_xbank = 1'b0;
    #1 chk("R7", "old value before edge", ra_data, 8'h00);
    @(negedge clk);
    we = 1'b0;
    #1 chk("R7", "new value after edge", ra_data, 8'ha2);
  endtask

  task automatic t_bank_priority();
    logic [7:0] d;
    pulse_bank(1'b1, 1'b1);
    chk("R8", "clear wins over set", {7'b0, bank_sel}, 8'h00);
    pulse_bank(1'b1, 1'b0);
    @(negedge clk); @(negedge clk);
    chk("R8", "flag holds", {7'b0, bank_sel}, 8'h01);
    pulse_bank(1'b0, 1'b1);
    @(negedge clk);
    we = 1'b1; wa_mode = M_CUR; wa_num = 3'd1; wa_xbank = 1'b0; wd = 8'h1a;
    bank_set = 1'b1;
    @(negedge clk);
    we = 1'b0; bank_set = 1'b0;
    raw(1, d); chk("R10", "write used old bank", d, 8'h1a);
    raw(9, d); chk("R10", "new bank not written", d, 8'h00);
    chk("R10", "flag updated", {7'b0, bank_sel}, 8'h01);
    pulse_bank(1'b0, 1'b1);
  endtask

  task automatic t_dual_port();
    @(negedge clk);
    ra_mode = M_RAW; ra_num = 3'd4; ra_xbank = 1'b1;
    rb_mode = M_SEG; rb_num = 3'd3; rb_xbank = 1'b0;
    #1;
    chk("R9", "port a code segment", ra_data, 8'hc0);
    chk("R9", "port b stack segment", rb_data, 8'hf0);
    rb_mode = M_RAW; rb_num = 3'd6; rb_xbank = 1'b0;
    #1;
    chk("R9", "port a unchanged", ra_data, 8'hc0);
    chk("R9", "port b stack pointer", rb_data, 8'h66);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_current_bank();
    t_explicit_bank();
    t_segments();
    t_raw();
    t_no_write();
    t_no_bypass();
    t_bank_priority();
    t_dual_port();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule